// File: doc/BRIEF.md
# Dual-Channel PWM Compare Output Unit

This block is the waveform core of a 16-bit timer. It has one counter and two compare channels, A and B. Each channel owns one output pin. A 4-bit waveform selector picks the counting scheme and the source of the TOP value:

- a single-slope sawtooth (fast PWM);
- a dual-slope triangle, which serves both the phase-correct and the phase-and-frequency-correct selections.

The counter advances only on cycles where the tick enable is high. An external prescaler therefore sets the count rate.

Each channel has its own 2-bit output mode. The mode decides how the pin reacts to compare matches, and in the sawtooth scheme also to the counter being at BOTTOM (zero). The choices are disconnected, toggle, non-inverting and inverting. A per-pin drive enable tells the surrounding pad logic when the waveform owns the pin. The counter value is exported for observation.

Top module: `pwm_cmp_unit`

## Requirements
- R1: While `rst` is high, at the following clock edge `count` becomes 0, both pins become 0 and the counting direction becomes upward.
- R2: A `wave_mode` other than 9, 11, 14 or 15 forces `count` to 0 at every edge and holds both drive enables low.
- R3: With `wave_mode` 14 or 15 the counter steps 0,1,…,TOP and then 0 again, one step per edge with `tick` high. TOP is `top_reg` in mode 14 and `cmp_a` in mode 15. With `tick` low, `count` is unchanged.
- R4: With `wave_mode` 9 or 11, TOP is `cmp_a`. On each tick the counter counts up to TOP, then down to 0, then up again. The step after TOP is TOP-1, and the step after 0 is 1 (or 0 if TOP is 0).
- R5: A channel mode of 00 drives that channel's enable low. Whenever an enable is low, its pin keeps its previous level.
- R6: Mode 01 on channel A enables the pin in all four supported waveform modes, and toggles it on a ticked cycle where `count` equals `cmp_a`. Mode 01 on channel B leaves `drv_b` low.
- R7: Sawtooth, mode 10: on a tick, the pin is set when `count` is 0 and cleared when `count` equals the channel's compare value.
- R8: Sawtooth, mode 11: on a tick, the pin is cleared when `count` is 0 and set when `count` equals the channel's compare value.
- R9: Sawtooth with mode 10 or 11: if the compare value equals TOP, the match has no effect, but the action at 0 still happens.
- R10: Sawtooth: when the match and the 0 action fall on the same tick (compare value 0), the match action decides the pin.
- R11: Triangle, mode 10: a tick with `count` equal to the compare value clears the pin if the current value was reached counting upward, and sets it if reached downward. A value at TOP counts as upward. A value of 0 reached after TOP counts as downward. The first value after reset, or after entering from another waveform mode, counts as upward.
- R12: Triangle, mode 11: the pin actions are the reverse of R11 (set on upward, clear on downward).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Count step enable |
| wave_mode | input | 4 | Waveform selector (9, 11, 14, 15 supported) |
| mode_a | input | 2 | Output mode of channel A |
| mode_b | input | 2 | Output mode of channel B |
| cmp_a | input | 16 | Compare value A, also TOP in modes 9, 11, 15 |
| cmp_b | input | 16 | Compare value B |
| top_reg | input | 16 | TOP value in mode 14 |
| pin_a | output | 1 | Waveform level of channel A |
| pin_b | output | 1 | Waveform level of channel B |
| drv_a | output | 1 | Channel A owns its pin |
| drv_b | output | 1 | Channel B owns its pin |
| count | output | 16 | Counter value |

## Verification
In the sawtooth scheme, the BOTTOM action and a compare match land on the same tick when a compare value is 0. A compare value equal to TOP pits the suppressed match against the later BOTTOM action. Dedicated phases set both channels to compare value 0, and then to compare value TOP, in non-inverting and inverting modes. A behavioural model in the bench gives the pin level after each tick. In the triangle scheme, matches at TOP and at 0 coincide with the direction reversal. These are provoked with `cmp_a` as TOP under toggle and inverting modes, and judged against the model's direction flag.

// File: rtl/pwm_cmp_pkg.sv
package pwm_cmp_pkg;

    typedef enum logic [1:0] {
        WK_OFF  = 2'd0,
        WK_FAST = 2'd1,
        WK_DUAL = 2'd2
    } wave_kind_e;

    typedef enum logic [1:0] {
        OM_OFF    = 2'b00,
        OM_TOGGLE = 2'b01,
        OM_NONINV = 2'b10,
        OM_INV    = 2'b11
    } out_mode_e;

    typedef struct packed {
        wave_kind_e kind;
        logic       top_from_reg;
    } wave_cfg_t;

    localparam logic [3:0] WM_DUAL_PF  = 4'd9;
    localparam logic [3:0] WM_DUAL_PC  = 4'd11;
    localparam logic [3:0] WM_FAST_REG = 4'd14;
    localparam logic [3:0] WM_FAST_CMP = 4'd15;

    function automatic wave_cfg_t decode_wave(input logic [3:0] sel);
        wave_cfg_t c;
        c.kind         = WK_OFF;
        c.top_from_reg = 1'b0;
        case (sel)
            WM_DUAL_PF, WM_DUAL_PC: c.kind = WK_DUAL;
            WM_FAST_REG: begin
                c.kind         = WK_FAST;
                c.top_from_reg = 1'b1;
            end
            WM_FAST_CMP: c.kind = WK_FAST;
            default: c.kind = WK_OFF;
        endcase
        return c;
    endfunction

    function automatic logic chan_owns_pin(input wave_kind_e k, input out_mode_e om,
                                           input logic toggle_ok);
        logic own;
        if (k == WK_OFF) begin
            own = 1'b0;
        end else begin
            case (om)
                OM_NONINV, OM_INV: own = 1'b1;
                OM_TOGGLE:         own = toggle_ok;
                default:           own = 1'b0;
            endcase
        end
        return own;
    endfunction

endpackage

// File: rtl/pwm_wave_decode.sv
module pwm_wave_decode
    import pwm_cmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic [3:0]       wave_mode,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] top_reg,
    output wave_cfg_t        cfg,
    output logic [CNT_W-1:0] top_val
);
    always_comb begin
        cfg     = decode_wave(wave_mode);
        top_val = cfg.top_from_reg ? top_reg : cmp_a;
    end
endmodule

// File: rtl/pwm_slope_counter.sv
module pwm_slope_counter
    import pwm_cmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  wave_cfg_t        cfg,
    input  logic [CNT_W-1:0] top_val,
    output logic [CNT_W-1:0] count,
    output logic             rising
);
    localparam logic [CNT_W-1:0] ONE  = {{(CNT_W-1){1'b0}}, 1'b1};
    localparam logic [CNT_W-1:0] ZERO = '0;

    logic [CNT_W-1:0] cnt_n;
    logic             rise_n;

    always_comb begin
        cnt_n  = count;
        rise_n = rising;
        case (cfg.kind)
            WK_FAST: begin
                rise_n = 1'b1;
                if (tick) begin
                    cnt_n = (count >= top_val) ? ZERO : count + ONE;
                end
            end
            WK_DUAL: begin
                if (tick) begin
                    if (rising) begin
                        if (count >= top_val) begin
                            rise_n = 1'b0;
                            cnt_n  = (count != ZERO) ? count - ONE : ZERO;
                        end else begin
                            cnt_n = count + ONE;
                        end
                    end else begin
                        if (count == ZERO) begin
                            rise_n = 1'b1;
                            cnt_n  = (top_val != ZERO) ? ONE : ZERO;
                        end else begin
                            cnt_n = count - ONE;
                        end
                    end
                end
            end
            default: begin
                cnt_n  = ZERO;
                rise_n = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            count  <= ZERO;
            rising <= 1'b1;
        end else begin
            count  <= cnt_n;
            rising <= rise_n;
        end
    end
endmodule

// File: rtl/pwm_out_chan.sv
module pwm_out_chan
    import pwm_cmp_pkg::*;
#(
    parameter int CNT_W     = 16,
    parameter bit TOGGLE_OK = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  wave_cfg_t        cfg,
    input  logic [1:0]       mode,
    input  logic [CNT_W-1:0] cmp,
    input  logic [CNT_W-1:0] top_val,
    input  logic [CNT_W-1:0] count,
    input  logic             rising,
    output logic             pin,
    output logic             drv
);
    out_mode_e om;
    logic      hit;
    logic      at_bottom;
    logic      top_clash;
    logic      pin_n;

    always_comb begin
        om        = out_mode_e'(mode);
        drv       = chan_owns_pin(cfg.kind, om, TOGGLE_OK);
        hit       = (count == cmp);
        at_bottom = (count == '0);
        top_clash = mode[1] && (cmp == top_val);
        pin_n     = pin;
        if (tick && drv) begin
            case (cfg.kind)
                WK_FAST: begin
                    // bottom first, a match in the same tick overrides it
                    if (mode[1] && at_bottom) pin_n = ~mode[0];
                    if (hit && !top_clash) begin
                        pin_n = (om == OM_TOGGLE) ? ~pin : mode[0];
                    end
                end
                WK_DUAL: begin
                    if (hit) begin
                        if (om == OM_TOGGLE) pin_n = ~pin;
                        else                 pin_n = rising ? mode[0] : ~mode[0];
                    end
                end
                default: pin_n = pin;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pin <= 1'b0;
        else     pin <= pin_n;
    end
endmodule

// File: rtl/pwm_cmp_unit.sv
module pwm_cmp_unit
    import pwm_cmp_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [3:0]       wave_mode,
    input  logic [1:0]       mode_a,
    input  logic [1:0]       mode_b,
    input  logic [CNT_W-1:0] cmp_a,
    input  logic [CNT_W-1:0] cmp_b,
    input  logic [CNT_W-1:0] top_reg,
    output logic             pin_a,
    output logic             pin_b,
    output logic             drv_a,
    output logic             drv_b,
    output logic [CNT_W-1:0] count
);
    localparam int NCH = 2;

    wave_cfg_t        cfg;
    logic [CNT_W-1:0] top_val;
    logic             rising;

    logic [NCH-1:0][1:0]       ch_mode;
    logic [NCH-1:0][CNT_W-1:0] ch_cmp;
    logic [NCH-1:0]            ch_pin;
    logic [NCH-1:0]            ch_drv;

    assign ch_mode = {mode_b, mode_a};
    assign ch_cmp  = {cmp_b, cmp_a};

    pwm_wave_decode #(.CNT_W(CNT_W)) u_decode (
        .wave_mode (wave_mode),
        .cmp_a     (cmp_a),
        .top_reg   (top_reg),
        .cfg       (cfg),
        .top_val   (top_val)
    );

    pwm_slope_counter #(.CNT_W(CNT_W)) u_counter (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .cfg     (cfg),
        .top_val (top_val),
        .count   (count),
        .rising  (rising)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        pwm_out_chan #(
            .CNT_W     (CNT_W),
            .TOGGLE_OK (i == 0)
        ) u_chan (
            .clk     (clk),
            .rst     (rst),
            .tick    (tick),
            .cfg     (cfg),
            .mode    (ch_mode[i]),
            .cmp     (ch_cmp[i]),
            .top_val (top_val),
            .count   (count),
            .rising  (rising),
            .pin     (ch_pin[i]),
            .drv     (ch_drv[i])
        );
    end

    assign pin_a = ch_pin[0];
    assign pin_b = ch_pin[1];
    assign drv_a = ch_drv[0];
    assign drv_b = ch_drv[1];
endmodule

// File: rtl/pwm_cmp_unit_chk.sv
module pwm_cmp_unit_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             tick,
    input logic [3:0]       wave_mode,
    input logic [1:0]       mode_b,
    input logic [CNT_W-1:0] cmp_a,
    input logic [CNT_W-1:0] top_reg,
    input logic             pin_a,
    input logic             pin_b,
    input logic             drv_a,
    input logic             drv_b,
    input logic [CNT_W-1:0] count
);
    logic             is_fast;
    logic             is_dual;
    logic [CNT_W-1:0] chk_top;

    assign is_fast = (wave_mode == 4'd14) || (wave_mode == 4'd15);
    assign is_dual = (wave_mode == 4'd9) || (wave_mode == 4'd11);
    assign chk_top = (wave_mode == 4'd14) ? top_reg : cmp_a;

    p_reset_r1: assert property (@(posedge clk)
        rst |=> (count == '0) && !pin_a && !pin_b);

    p_off_count_r2: assert property (@(posedge clk) disable iff (rst)
        (!is_fast && !is_dual) |=> (count == '0));

    p_off_drive_r2: assert property (@(posedge clk) disable iff (rst)
        (!is_fast && !is_dual) |-> (!drv_a && !drv_b));

    p_no_tick_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!tick && (is_fast || is_dual)) |=> $stable(count));

    p_fast_wrap_r3: assert property (@(posedge clk) disable iff (rst)
        (tick && is_fast && count == chk_top) |=> (count == '0));

    p_hold_a_r5: assert property (@(posedge clk) disable iff (rst)
        !drv_a |=> $stable(pin_a));

    p_hold_b_r5: assert property (@(posedge clk) disable iff (rst)
        !drv_b |=> $stable(pin_b));

    p_b_no_toggle_r6: assert property (@(posedge clk) disable iff (rst)
        (mode_b == 2'b01) |-> !drv_b);
endmodule

bind pwm_cmp_unit pwm_cmp_unit_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .tick      (tick),
    .wave_mode (wave_mode),
    .mode_b    (mode_b),
    .cmp_a     (cmp_a),
    .top_reg   (top_reg),
    .pin_a     (pin_a),
    .pin_b     (pin_b),
    .drv_a     (drv_a),
    .drv_b     (drv_b),
    .count     (count)
);

// File: tb/pwm_cmp_unit_tb.sv
`timescale 1ns/1ps
module pwm_cmp_unit_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        tick = 1'b0;
    logic [3:0]  wave_mode = 4'd0;
    logic [1:0]  mode_a = 2'd0;
    logic [1:0]  mode_b = 2'd0;
    logic [15:0] cmp_a = '0;
    logic [15:0] cmp_b = '0;
    logic [15:0] top_reg = '0;
    logic        pin_a, pin_b, drv_a, drv_b;
    logic [15:0] count;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // reference state
    int m_cnt = 0;
    bit m_up = 1'b1;
    bit m_pa = 1'b0;
    bit m_pb = 1'b0;
    bit e_da = 1'b0;
    bit e_db = 1'b0;

    always #4 clk = ~clk;

    pwm_cmp_unit u_dut (
        .clk (clk), .rst (rst), .tick (tick), .wave_mode (wave_mode),
        .mode_a (mode_a), .mode_b (mode_b), .cmp_a (cmp_a), .cmp_b (cmp_b),
        .top_reg (top_reg), .pin_a (pin_a), .pin_b (pin_b),
        .drv_a (drv_a), .drv_b (drv_b), .count (count)
    );

    function automatic int kind_of(input int wm);
        if (wm == 14 || wm == 15) return 1;
        if (wm == 9 || wm == 11)  return 2;
        return 0;
    endfunction

    function automatic bit owns(input int kind, input int om, input bit is_a);
        if (kind == 0) return 1'b0;
        if (om >= 2)   return 1'b1;
        if (om == 1)   return is_a;
        return 1'b0;
    endfunction

    function automatic bit next_pin(input int kind, input int om, input int cv, input int tv,
                                    input int cnt, input bit up, input bit pin, input bit is_a,
                                    input bit tk);
        bit r;
        r = pin;
        if (!tk || !owns(kind, om, is_a)) return pin;
        if (kind == 1) begin
            if (om >= 2 && cnt == 0) r = (om == 2);
            if (cnt == cv && !(om >= 2 && cv == tv)) r = (om == 1) ? !pin : (om == 3);
        end else if (cnt == cv) begin
            if (om == 1)      r = !pin;
            else if (om == 2) r = !up;
            else              r = up;
        end
        return r;
    endfunction

    task automatic model_step();
        int kind, tv;
        kind = kind_of(int'(wave_mode));
        tv   = (wave_mode == 4'd14) ? int'(top_reg) : int'(cmp_a);
        e_da = owns(kind, int'(mode_a), 1'b1);
        e_db = owns(kind, int'(mode_b), 1'b0);
        m_pa = next_pin(kind, int'(mode_a), int'(cmp_a), tv, m_cnt, m_up, m_pa, 1'b1, tick);
        m_pb = next_pin(kind, int'(mode_b), int'(cmp_b), tv, m_cnt, m_up, m_pb, 1'b0, tick);
        if (kind == 0) begin
            m_cnt = 0;
            m_up  = 1'b1;
        end else if (kind == 1) begin
            m_up = 1'b1;
            if (tick) m_cnt = (m_cnt >= tv) ? 0 : m_cnt + 1;
        end else if (tick) begin
            if (m_up) begin
                if (m_cnt >= tv) begin
                    m_up = 1'b0;
                    if (m_cnt > 0) m_cnt = m_cnt - 1;
                end else begin
                    m_cnt = m_cnt + 1;
                end
            end else if (m_cnt == 0) begin
                m_up = 1'b1;
                if (tv > 0) m_cnt = 1;
            end else begin
                m_cnt = m_cnt - 1;
            end
        end
    endtask

    task automatic compare(input string tag);
        n_vec++;
        if (count !== 16'(m_cnt) || pin_a !== m_pa || pin_b !== m_pb ||
            drv_a !== e_da || drv_b !== e_db) begin
            n_bad++;
            $display("FAIL %s t=%0t: cnt/pa/pb/da/db actual %0d/%b/%b/%b/%b expected %0d/%b/%b/%b/%b",
                     tag, $time, count, pin_a, pin_b, drv_a, drv_b,
                     m_cnt, m_pa, m_pb, e_da, e_db);
        end
    endtask

    // called at a negedge with the configuration already applied
    task automatic run_phase(input string tag, input int n, input int tick_pct);
        for (int i = 0; i < n; i++) begin
            tick = (($urandom % 100) < tick_pct);
            model_step();
            @(negedge clk);
            compare(tag);
        end
    endtask

    task automatic setup(input int wm, input int ma, input int mb,
                         input int ca, input int cb, input int tr);
        wave_mode = 4'(wm);
        mode_a    = 2'(ma);
        mode_b    = 2'(mb);
        cmp_a     = 16'(ca);
        cmp_b     = 16'(cb);
        top_reg   = 16'(tr);
    endtask

    initial begin
        #(200000 * 8);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 reset state, with the counter otherwise busy
        setup(14, 2, 3, 3, 5, 9);
        tick = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        m_cnt = 0; m_up = 1'b1; m_pa = 1'b0; m_pb = 1'b0;
        e_da = 1'b1; e_db = 1'b1;
        compare("R1 reset");
        rst = 1'b0;

        // R2 unsupported waveform selector
        setup(0, 2, 3, 2, 4, 9);
        run_phase("R2 mode 0", 12, 100);
        setup(12, 1, 2, 2, 4, 9);
        run_phase("R2 mode 12", 12, 100);

        // R3 R7 R8 sawtooth, TOP from top_reg
        setup(14, 2, 3, 3, 7, 9);
        run_phase("R3/R7/R8 fast full tick", 40, 100);
        run_phase("R3 fast gated tick", 40, 50);

        // R6 toggle on A in mode 15, B disconnected
        setup(15, 1, 1, 12, 5, 3);
        run_phase("R6 fast toggle", 50, 100);

        // R9 compare equal to TOP
        setup(14, 2, 3, 8, 8, 8);
        run_phase("R9 cmp at top", 40, 100);

        // R10 match and bottom together
        setup(14, 2, 3, 0, 0, 6);
        run_phase("R10 match at bottom", 40, 100);

        // R5 disconnect holds pins
        setup(14, 0, 0, 2, 4, 6);
        run_phase("R5 disconnected", 20, 100);
        setup(14, 2, 0, 2, 4, 6);
        run_phase("R5 b only off", 20, 100);

        // R4 R6 R11 triangle
        setup(9, 1, 2, 10, 4, 0);
        run_phase("R4/R6/R11 dual toggle+noninv", 60, 100);
        setup(11, 3, 3, 7, 2, 0);
        run_phase("R4/R12 dual inverting", 60, 60);
        setup(11, 2, 2, 5, 0, 0);
        run_phase("R11 dual match at zero", 40, 100);

        // R3/R4 random mix
        for (int k = 0; k < 40; k++) begin
            int pick;
            pick = $urandom % 6;
            setup((pick == 0) ? 9 : (pick == 1) ? 11 : (pick == 2) ? 14 :
                  (pick == 3) ? 15 : (pick == 4) ? 0 : int'($urandom % 16),
                  int'($urandom % 4), int'($urandom % 4),
                  int'($urandom % 21), int'($urandom % 23), int'($urandom % 21));
            run_phase("R3/R4 random mix", 50, 80);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule